// File: doc/BRIEF.md
# Search ROM Triplet Engine

This block runs the bit-by-bit identity search on a single-wire device bus in hardware. The reset and the search command have already gone out. For every ID bit, starting at the least significant, the engine asks a slot-level bus controller for two read slots and then one write slot. The first read gives the true bit that all still-selected devices drive onto the wired-AND line. The second read gives its complement. From the two results the engine picks the bit to write back, and only devices whose ID holds that bit stay in the search.

The host supplies a direction word. At each position where the devices disagree, the matching direction bit picks the branch, and the engine sets that position in a discrepancy map. A pass ends in one of three ways: with an ID and its discrepancy map, with an error when no device answers, or back in idle when the host drops the enable. The host can then plan the next direction word from the map without touching single bits.

Top module: `srch_triplet_eng`

## Requirements
- R1: After reset, busy_o, done_o, err_o, refused_o and slot_req_o are 0, and id_o and disc_o are all zeros.
- R2: A start_i pulse in idle, with en_i and rx_empty_i both 1, clears id_o, disc_o, done_o and err_o, raises busy_o and begins a pass at bit 0.
- R3: A start_i pulse in idle, with en_i at 1 and rx_empty_i at 0, is refused. refused_o is 1 for exactly one cycle, no slot is requested and busy_o stays 0.
- R4: Each ID bit uses three slots in a fixed order: true read, complement read, write. slot_wr_o is 0 for a read and 1 for a write. slot_req_o is a one-cycle pulse, and the next request waits for slot_done_i.
- R5: Bits are searched least significant first. The bit decided in the k-th triplet lands in id_o[k-1] and disc_o[k-1].
- R6: When the two reads differ (01 or 10), the write slot sends the first read bit, id_o takes that bit, and the disc_o bit stays 0.
- R7: When both reads are 0, the write slot sends dir_i at that position, id_o takes the same value, and the disc_o bit is set to 1.
- R8: When both reads are 1, err_o goes to 1, no write slot follows, busy_o falls and done_o stays 0.
- R9: done_o goes to 1 after the last write slot completes. After that, id_o and disc_o hold their values until the next accepted start, even if dir_i changes.
- R10: If en_i falls during a pass, the slot in progress completes, no further slot is requested, the engine returns to idle, and done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Engine enable; dropping it aborts the pass after the current slot |
| start_i | input | 1 | One-cycle request to begin a pass |
| rx_empty_i | input | 1 | High when the receive buffer holds no data |
| dir_i | input | ID_W | Branch choice for each bit position where devices disagree |
| slot_req_o | output | 1 | One-cycle request for a bus slot |
| slot_wr_o | output | 1 | Slot type with the request: 0 read, 1 write |
| slot_wbit_o | output | 1 | Bit to send in a write slot |
| slot_done_i | input | 1 | One-cycle completion of the requested slot |
| slot_rbit_i | input | 1 | Bit sampled in a read slot, valid with slot_done_i |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | The last pass finished all bits |
| err_o | output | 1 | The last pass found no responding device |
| refused_o | output | 1 | One-cycle flag for a refused start |
| id_o | output | ID_W | Discovered ID, least significant bit first |
| disc_o | output | ID_W | Positions where devices disagreed |

## Verification
The assertions rely on the slot controller to return exactly one slot_done_i pulse for each request, never one without a request outstanding, with slot_rbit_i valid alongside it. They also rely on dir_i staying constant while a pass runs. The bench's bus model follows these rules: it answers each request once, a few cycles later, and computes the read bits as the wired-AND of the ID bits of the devices still selected. It changes dir_i only while the engine is idle.

// File: rtl/srch_pkg.sv
package srch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD_T = 2'd1,
    ST_RD_C = 2'd2,
    ST_WR   = 2'd3
  } srch_st_e;
endpackage

// File: rtl/srch_rst_sync.sv
module srch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sh_q[STAGES-1];
endmodule

// File: rtl/srch_bitctr.sv
module srch_bitctr #(
  parameter int ID_W = 64,
  localparam int IW = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)      idx_d = '0;
    else if (inc_i) idx_d = idx_q + IW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_q <= '0;
    else if (clr_i || inc_i)  idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IW'(ID_W - 1));

  // R5: the position never runs past the last ID bit
  a_r5_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idx_q) < ID_W);
  // R5: positions advance by one, lowest first
  a_r5_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (idx_q == $past(idx_q) + IW'(1)));
endmodule

// File: rtl/srch_decide.sv
module srch_decide (
  input  logic b_true_i,
  input  logic b_comp_i,
  input  logic dir_bit_i,
  output logic wbit_o,
  output logic fork_o,
  output logic none_o
);
  always_comb begin
    fork_o = 1'b0;
    none_o = 1'b0;
    wbit_o = b_true_i;
    unique case ({b_true_i, b_comp_i})
      2'b00: begin
        fork_o = 1'b1;
        wbit_o = dir_bit_i;
      end
      2'b11: begin
        none_o = 1'b1;
        wbit_o = 1'b0;
      end
      default: wbit_o = b_true_i;
    endcase
  end
endmodule

// File: rtl/srch_result.sv
module srch_result #(
  parameter int ID_W = 64,
  localparam int IW = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            set_i,
  input  logic [IW-1:0]   idx_i,
  input  logic            bit_i,
  input  logic            fork_i,
  output logic [ID_W-1:0] id_o,
  output logic [ID_W-1:0] disc_o
);
  for (genvar g = 0; g < ID_W; g++) begin : g_bit
    logic hit;
    logic id_d, disc_d;
    assign hit = set_i && (idx_i == IW'(g));

    always_comb begin
      id_d   = id_o[g];
      disc_d = disc_o[g];
      if (clr_i) begin
        id_d   = 1'b0;
        disc_d = 1'b0;
      end else if (hit) begin
        id_d   = bit_i;
        disc_d = fork_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_o[g]   <= 1'b0;
        disc_o[g] <= 1'b0;
      end else if (clr_i || hit) begin
        id_o[g]   <= id_d;
        disc_o[g] <= disc_d;
      end
    end
  end

  // R7: a disagreement leaves its map bit set at that position
  a_r7_fork_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && fork_i && !clr_i) |=> disc_o[$past(idx_i)]);
  // R6: an agreeing position leaves its map bit clear
  a_r6_agree_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !fork_i && !clr_i) |=> !disc_o[$past(idx_i)]);
endmodule

// File: rtl/srch_triplet_eng.sv
module srch_triplet_eng #(
  parameter int ID_W = 64,
  localparam int IW = (ID_W > 1) ? $clog2(ID_W) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            start_i,
  input  logic            rx_empty_i,
  input  logic [ID_W-1:0] dir_i,
  output logic            slot_req_o,
  output logic            slot_wr_o,
  output logic            slot_wbit_o,
  input  logic            slot_done_i,
  input  logic            slot_rbit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            refused_o,
  output logic [ID_W-1:0] id_o,
  output logic [ID_W-1:0] disc_o
);
  import srch_pkg::*;

  logic srst_n;
  srch_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(srst_n));

  srch_st_e st_q, st_d;
  logic issued_q, issued_d;
  logic btrue_q, btrue_d;
  logic wbit_q, wbit_d;
  logic done_q, done_d, err_q, err_d, refused_q;

  logic go, refuse, accept, in_slot;
  logic [IW-1:0] idx;
  logic last;
  logic dec_wbit, dec_fork, dec_none;
  logic ctr_inc, res_set;

  assign in_slot = (st_q != ST_IDLE);
  assign go      = start_i && en_i && !in_slot && rx_empty_i;
  assign refuse  = start_i && en_i && !in_slot && !rx_empty_i;
  assign accept  = in_slot && issued_q && slot_done_i;

  srch_decide u_dec (
    .b_true_i (btrue_q),
    .b_comp_i (slot_rbit_i),
    .dir_bit_i(dir_i[idx]),
    .wbit_o   (dec_wbit),
    .fork_o   (dec_fork),
    .none_o   (dec_none));

  assign ctr_inc = accept && (st_q == ST_WR) && !last;
  assign res_set = accept && (st_q == ST_RD_C) && !dec_none;

  srch_bitctr #(.ID_W(ID_W)) u_ctr (
    .clk_i (clk_i), .rst_ni(srst_n),
    .clr_i (go),    .inc_i (ctr_inc),
    .idx_o (idx),   .last_o(last));

  srch_result #(.ID_W(ID_W)) u_res (
    .clk_i (clk_i), .rst_ni(srst_n),
    .clr_i (go),    .set_i (res_set),
    .idx_i (idx),   .bit_i (dec_wbit), .fork_i(dec_fork),
    .id_o  (id_o),  .disc_o(disc_o));

  // next-state logic
  always_comb begin
    st_d     = st_q;
    issued_d = issued_q;
    btrue_d  = btrue_q;
    wbit_d   = wbit_q;
    done_d   = done_q;
    err_d    = err_q;
    if (go) begin
      st_d     = ST_RD_T;
      issued_d = 1'b0;
      done_d   = 1'b0;
      err_d    = 1'b0;
    end else if (in_slot && !issued_q) begin
      if (!en_i) st_d     = ST_IDLE;
      else       issued_d = 1'b1;
    end else if (accept) begin
      issued_d = 1'b0;
      unique case (st_q)
        ST_RD_T: begin
          btrue_d = slot_rbit_i;
          st_d    = en_i ? ST_RD_C : ST_IDLE;
        end
        ST_RD_C: begin
          if (dec_none) begin
            err_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            wbit_d = dec_wbit;
            st_d   = en_i ? ST_WR : ST_IDLE;
          end
        end
        ST_WR: begin
          if (last) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = en_i ? ST_RD_T : ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      st_q      <= ST_IDLE;
      issued_q  <= 1'b0;
      btrue_q   <= 1'b0;
      wbit_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      refused_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      issued_q  <= issued_d;
      btrue_q   <= btrue_d;
      wbit_q    <= wbit_d;
      done_q    <= done_d;
      err_q     <= err_d;
      refused_q <= refuse;
    end
  end

  assign slot_req_o  = in_slot && !issued_q && en_i;
  assign slot_wr_o   = (st_q == ST_WR);
  assign slot_wbit_o = wbit_q;
  assign busy_o      = in_slot;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign refused_o   = refused_q;

  // R4: a request lasts one cycle only
  a_r4_req_pulse: assert property (@(posedge clk_i) disable iff (!srst_n)
    slot_req_o |=> !slot_req_o);
  // R3: a refused start leaves the engine idle and flags it
  a_r3_refuse: assert property (@(posedge clk_i) disable iff (!srst_n)
    (start_i && en_i && !rx_empty_i && !busy_o) |=> (refused_o && !busy_o));
  // R3: the refusal flag lasts one cycle
  a_r3_refuse_pulse: assert property (@(posedge clk_i) disable iff (!srst_n)
    refused_o |=> !refused_o || $past(start_i));
  // R8: a silent bus ends the pass without completion
  a_r8_err_stops: assert property (@(posedge clk_i) disable iff (!srst_n)
    $rose(err_o) |-> (!busy_o && !done_o));
  // R9: results hold after completion until a new start
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!srst_n)
    (done_o && !start_i) |=> ($stable(id_o) && $stable(disc_o)));
  // R10: no request while disabled
  a_r10_no_req_off: assert property (@(posedge clk_i) disable iff (!srst_n)
    !en_i |-> !slot_req_o);
endmodule

// File: tb/sim_srch_triplet_eng.sv
module sim_srch_triplet_eng;
  localparam int W = 8;
  localparam int ND = 3;

  logic clk, rst_n, en, start, rx_empty;
  logic [W-1:0] dir;
  logic slot_req, slot_wr, slot_wbit, slot_done, slot_rbit;
  logic busy, done, err, refused;
  logic [W-1:0] id, disc;

  srch_triplet_eng #(.ID_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start),
    .rx_empty_i(rx_empty), .dir_i(dir),
    .slot_req_o(slot_req), .slot_wr_o(slot_wr), .slot_wbit_o(slot_wbit),
    .slot_done_i(slot_done), .slot_rbit_i(slot_rbit),
    .busy_o(busy), .done_o(done), .err_o(err), .refused_o(refused),
    .id_o(id), .disc_o(disc));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;
  int req_cnt = 0;
  int wr_cnt = 0;
  int order_err = 0;

  logic [W-1:0] dev [ND];
  logic [ND-1:0] act;
  int pos;
  int phase;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (slot_req) req_cnt <= req_cnt + 1;
  end

  function automatic logic [ND-1:0] col(input int p);
    logic [ND-1:0] v;
    for (int d = 0; d < ND; d++) v[d] = dev[d][p];
    return v;
  endfunction

  // bus model: wired-AND of still-selected devices
  initial begin
    slot_done = 1'b0;
    slot_rbit = 1'b0;
    forever begin
      @(negedge clk);
      while (slot_req === 1'b1) begin
        automatic logic wr = slot_wr;
        automatic logic wb = slot_wbit;
        automatic logic [ND-1:0] bv = col(pos);
        if (wr != (phase == 2)) order_err++;
        @(negedge clk);
        @(negedge clk);
        if (!wr) begin
          if (phase == 0) slot_rbit = &(~act | bv);
          else            slot_rbit = &(~act | ~bv);
          phase = phase + 1;
        end else begin
          wr_cnt++;
          act = act & ~(bv ^ {ND{wb}});
          phase = 0;
          pos = pos + 1;
        end
        slot_done = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act_v,
                     input logic [63:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  task automatic ref_walk(input logic [W-1:0] d, input logic [ND-1:0] m,
                          output logic [W-1:0] eid, output logic [W-1:0] edisc);
    logic [ND-1:0] a = m;
    eid = '0; edisc = '0;
    for (int i = 0; i < W; i++) begin
      automatic logic [ND-1:0] bv = col(i);
      automatic logic b;
      if ((a & bv) != 0 && (a & ~bv) != 0) begin
        edisc[i] = 1'b1;
        b = d[i];
      end else begin
        b = ((a & bv) != 0);
      end
      eid[i] = b;
      a = a & ~(bv ^ {ND{b}});
    end
  endtask

  task automatic launch(input logic [W-1:0] d, input logic [ND-1:0] m);
    dir = d; act = m; pos = 0; phase = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_pass(input logic [W-1:0] d, input logic [ND-1:0] m);
    logic [W-1:0] eid, edisc;
    int w0;
    w0 = wr_cnt;
    launch(d, m);
    while (!(done || err)) @(negedge clk);
    ref_walk(d, m, eid, edisc);
    // R5 R6 R7: ID and map from the branch picked bit by bit
    chk(id == eid, "R5/R6/R7 id", 64'(id), 64'(eid));
    chk(disc == edisc, "R7 disc", 64'(disc), 64'(edisc));
    // R9: completion after all write slots
    chk(done && !err && !busy && (wr_cnt - w0 == W), "R9 done",
        64'({done, err, busy}), 64'(3'b100));
  endtask

  initial begin
    int timeout_hit = 0;
    while (cyc < 150000 && !finished) @(negedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; start = 1'b0; rx_empty = 1'b1; dir = '0;
    act = '0; pos = 0; phase = 0;
    dev[0] = 8'hA5; dev[1] = 8'h3C; dev[2] = 8'hA1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    chk({busy, done, err, refused, slot_req} == 5'b0, "R1 flags",
        64'({busy, done, err, refused, slot_req}), 64'(0));
    chk(id == '0 && disc == '0, "R1 results", 64'({id, disc}), 64'(0));

    en = 1'b1;
    // R3: refused start
    begin
      automatic int r0 = req_cnt;
      rx_empty = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(refused && !busy, "R3 refused", 64'({refused, busy}), 64'(2'b10));
      @(negedge clk);
      chk(!refused, "R3 one cycle", 64'(refused), 64'(0));
      repeat (10) @(negedge clk);
      chk(req_cnt == r0 && !busy, "R3 no slot", 64'(req_cnt), 64'(r0));
      rx_empty = 1'b1;
    end

    // R2: accepted start
    launch(8'h00, 3'b111);
    chk(busy && !done && id == '0, "R2 busy", 64'({busy, done}), 64'(2'b10));
    while (!(done || err)) @(negedge clk);
    chk(order_err == 0, "R4 slot order", 64'(order_err), 64'(0));

    // R5 R6 R7 R9: full sweep of directions with all devices present
    for (int d = 0; d < 256; d++) run_pass(W'(d), 3'b111);
    // sweep device subsets with a range of directions
    for (int m = 1; m < 7; m++)
      for (int d = 0; d < 32; d++) run_pass(W'(d * 7), ND'(m));
    chk(order_err == 0, "R4 slot order sweep", 64'(order_err), 64'(0));

    // R6: single device, no disagreements
    run_pass(8'hFF, 3'b010);
    chk(disc == '0 && id == dev[1], "R6 single", 64'({id, disc}), 64'({dev[1], 8'h00}));

    // R9: hold after done while dir changes
    begin
      automatic logic [W-1:0] hid = id, hdisc = disc;
      dir = ~dir;
      repeat (20) @(negedge clk);
      chk(id == hid && disc == hdisc && done, "R9 hold", 64'({id, disc}),
          64'({hid, hdisc}));
    end

    // R8: no device answers
    begin
      automatic int w0 = wr_cnt;
      launch(8'h00, 3'b000);
      while (!(done || err)) @(negedge clk);
      chk(err && !done && !busy, "R8 error", 64'({err, done, busy}), 64'(3'b100));
      chk(wr_cnt == w0, "R8 no write", 64'(wr_cnt - w0), 64'(0));
    end

    // R10: enable dropped mid-pass
    begin
      automatic int r0 = req_cnt;
      launch(8'h55, 3'b111);
      while (req_cnt < r0 + 5) @(negedge clk);
      en = 1'b0;
      repeat (30) @(negedge clk);
      chk(!busy && !done && !err, "R10 idle", 64'({busy, done, err}), 64'(0));
      chk(req_cnt == r0 + 5, "R10 no more slots", 64'(req_cnt - r0), 64'(5));
      chk(slot_done == 1'b0, "R10 slot finished", 64'(slot_done), 64'(0));
      en = 1'b1;
    end

    // R2: restart after abort clears and completes
    run_pass(8'hC3, 3'b111);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule